// File: doc/BRIEF.md
# Sequenced Product-Line Activator for Array Self-Test

This block lets a self-test routine select one product term of an AND/OR logic array at a time, using only a single mode input and no extra pins. An internal code generator steps through a fixed sequence of binary codes, one per clock. A small comparator array maps each code to one activation line, so exactly one line is driven high for each code. The generator is a shift register with equivalence (XNOR) feedback. The all-zeros word is therefore an ordinary member of its cycle, and the all-ones word is the single state it never leaves. The block uses that stuck word as its off code.

The mode input has two settings. While it is low, the register holds the all-ones word and no line is driven. When it goes high, the register loads all zeros and the walk begins. One extra comparator row recognises the code of the last line and forces a reload of the zero seed. This keeps the repetition period equal to the number of lines, even though the generator's natural cycle is longer. The register's top bit is brought out as a serial observation pin. The code width is derived from the line count as ceil(log2(lines + 1)).

Top module: `plact_top`

## Requirements
- R1: A synchronous reset (rst_i high at a clock edge) puts the code register in the all-ones word: after that edge scan_o is 1, and line_act_o is all zeros.
- R2: While test_en_i is 0, line_act_o is all zeros and restart_o is 0 in that same cycle, whatever the register holds.
- R3: At the first clock edge where test_en_i is 1 after having been 0 (or after reset), the register loads all zeros. In the following cycle only bit 0 of line_act_o (line 0) is high.
- R4: At each later test-mode edge the register shifts left by one. The vacated bit 0 takes the XNOR of bits 3 and 2. Line i is tied to the i-th code of this walk from 0000: 0000, 0001, 0011, 0111, 1110, 1101, 1011, 0110 for lines 0 to 7. In every test cycle after the entry edge, exactly one bit of line_act_o is high.
- R5: After line 7 (the last, NUM_LINES-1) is active, the next test-mode edge returns to line 0. Line activation therefore repeats with period NUM_LINES.
- R6: restart_o is high exactly in the test cycles where line 7 is active.
- R7: scan_o is bit 3 (the MSB) of the code register. Across one period starting from line 0 it shows 0,0,0,0,1,1,1,0.
- R8: At the first edge with test_en_i at 0, the register reloads all ones. It then stays there (scan_o = 1) for as long as test_en_i stays 0.
- R9: In the cycle where test_en_i has just risen but the register still holds all ones, no line is active.
- R10: Dropping test_en_i for one or more cycles and raising it again restarts the walk at line 0, not where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| test_en_i | input | 1 | 1 = self-test walk, 0 = normal (activator off) |
| line_act_o | output | NUM_LINES | One-hot activation of the product lines |
| restart_o | output | 1 | Recognizer row: high on the last line's code |
| scan_o | output | 1 | Serial observation of the code register MSB |

## Verification
The assertions assume test_en_i and rst_i are synchronous to clk_i and stable around each rising edge. They also take the one-hot property to hold only when the mode was already high at the previous edge and reset was not applied there. The bench changes inputs only on falling edges. It covers long test runs, single-cycle drops of the mode input, a re-entry in the middle of a period, and reset applied while the walk is running.

// File: rtl/plact_pkg.sv
package plact_pkg;

    // One step of the equivalence-feedback shift register of width w.
    function automatic logic [31:0] code_step(input logic [31:0] cur, input int w,
                                              input int hi, input int lo);
        logic [31:0] mask;
        logic        fb;
        mask = (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
        fb   = ~(cur[hi] ^ cur[lo]);
        return ((cur << 1) | {31'd0, fb}) & mask;
    endfunction

    // Code assigned to line idx: idx steps from the all-zeros seed.
    function automatic logic [31:0] line_code(input int idx, input int w,
                                              input int hi, input int lo);
        logic [31:0] c;
        c = 32'd0;
        for (int s = 0; s < idx; s++) begin
            c = code_step(c, w, hi, lo);
        end
        return c;
    endfunction

endpackage

// File: rtl/plact_codegen.sv
module plact_codegen #(
    parameter int CODE_W = 4,
    parameter int TAP_HI = 3,
    parameter int TAP_LO = 2
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              test_en_i,
    input  logic              restart_i,
    output logic [CODE_W-1:0] code_o
);
    import plact_pkg::*;

    localparam logic [CODE_W-1:0] SEED_ZERO = '0;
    localparam logic [CODE_W-1:0] LOCK_CODE = '1;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              mode;
    } gen_state_t;

    localparam gen_state_t RESET_STATE = '{code: LOCK_CODE, mode: 1'b0};

    gen_state_t st_d, st_q;
    logic [CODE_W-1:0] stepped;

    always_comb begin
        stepped = CODE_W'(code_step(32'(st_q.code), CODE_W, TAP_HI, TAP_LO));
        st_d      = st_q;
        st_d.mode = test_en_i;
        if (!test_en_i) begin
            st_d.code = LOCK_CODE;
        end else if (!st_q.mode) begin
            st_d.code = SEED_ZERO;
        end else if (restart_i) begin
            st_d.code = SEED_ZERO;
        end else begin
            st_d.code = stepped;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= RESET_STATE;
        end else begin
            st_q <= st_d;
        end
    end

    assign code_o = st_q.code;

endmodule

// File: rtl/plact_decoder.sv
module plact_decoder #(
    parameter int NUM_LINES = 8,
    parameter int CODE_W    = 4,
    parameter int TAP_HI    = 3,
    parameter int TAP_LO    = 2
) (
    input  logic                 enable_i,
    input  logic [CODE_W-1:0]    code_i,
    output logic [NUM_LINES-1:0] line_act_o,
    output logic                 recog_o
);
    import plact_pkg::*;

    localparam logic [CODE_W-1:0] LAST_CODE =
        CODE_W'(line_code(NUM_LINES - 1, CODE_W, TAP_HI, TAP_LO));

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_row
        localparam logic [CODE_W-1:0] ROW_CODE =
            CODE_W'(line_code(i, CODE_W, TAP_HI, TAP_LO));
        logic match;
        always_comb begin
            match = 1'b1;
            for (int b = 0; b < CODE_W; b++) begin
                if (code_i[b] != ROW_CODE[b]) match = 1'b0;
            end
        end
        assign line_act_o[i] = enable_i & match;
    end

    // Separate recognizer row, programmed like the bottom-most line.
    logic recog_match;
    always_comb begin
        recog_match = 1'b1;
        for (int b = 0; b < CODE_W; b++) begin
            if (code_i[b] != LAST_CODE[b]) recog_match = 1'b0;
        end
    end
    assign recog_o = enable_i & recog_match;

endmodule

// File: rtl/plact_top.sv
module plact_top #(
    parameter int NUM_LINES = 8
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 test_en_i,
    output logic [NUM_LINES-1:0] line_act_o,
    output logic                 restart_o,
    output logic                 scan_o
);
    localparam int CODE_W = $clog2(NUM_LINES + 1);
    localparam int TAP_HI = CODE_W - 1;
    localparam int TAP_LO = CODE_W - 2;

    logic [CODE_W-1:0] code;
    logic              recog;

    plact_codegen #(
        .CODE_W(CODE_W), .TAP_HI(TAP_HI), .TAP_LO(TAP_LO)
    ) u_gen (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .test_en_i(test_en_i),
        .restart_i(recog),
        .code_o   (code)
    );

    plact_decoder #(
        .NUM_LINES(NUM_LINES), .CODE_W(CODE_W), .TAP_HI(TAP_HI), .TAP_LO(TAP_LO)
    ) u_dec (
        .enable_i  (test_en_i),
        .code_i    (code),
        .line_act_o(line_act_o),
        .recog_o   (recog)
    );

    assign restart_o = recog;
    assign scan_o    = code[CODE_W-1];

endmodule

// File: rtl/plact_checker.sv
module plact_checker #(
    parameter int NUM_LINES = 8
) (
    input logic                 clk_i,
    input logic                 rst_i,
    input logic                 test_en_i,
    input logic [NUM_LINES-1:0] line_act_o,
    input logic                 restart_o,
    input logic                 scan_o
);
    logic prev_en_q;
    always_ff @(posedge clk_i) begin
        if (rst_i) prev_en_q <= 1'b0;
        else       prev_en_q <= test_en_i;
    end

    a_r2_idle_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
        !test_en_i |-> (line_act_o == '0 && !restart_o));

    a_r4_one_hot: assert property (@(posedge clk_i) disable iff (rst_i)
        (test_en_i && prev_en_q) |-> ($countones(line_act_o) == 1));

    a_r3_seed_line0: assert property (@(posedge clk_i) disable iff (rst_i)
        (test_en_i && !prev_en_q) |=> (!test_en_i || line_act_o[0]));

    a_r5_wrap: assert property (@(posedge clk_i) disable iff (rst_i)
        (test_en_i && line_act_o[NUM_LINES-1]) |=> (!test_en_i || line_act_o[0]));

    a_r6_recognizer: assert property (@(posedge clk_i) disable iff (rst_i)
        restart_o == line_act_o[NUM_LINES-1]);

    a_r8_lockup: assert property (@(posedge clk_i) disable iff (rst_i)
        !test_en_i |=> scan_o);

    a_r9_entry_dark: assert property (@(posedge clk_i) disable iff (rst_i)
        (test_en_i && !prev_en_q) |-> (line_act_o == '0));

endmodule

bind plact_top plact_checker #(.NUM_LINES(NUM_LINES)) u_plact_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .test_en_i (test_en_i),
    .line_act_o(line_act_o),
    .restart_o (restart_o),
    .scan_o    (scan_o)
);

// File: tb/test_plact_top.sv
module test_plact_top;
    localparam int M = 8;
    localparam int W = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;
    logic [M-1:0] act;
    logic restart, scan;

    always #10 clk = ~clk;   // 50 MHz

    plact_top #(.NUM_LINES(M)) i_plact_top (
        .clk_i(clk), .rst_i(rst), .test_en_i(en),
        .line_act_o(act), .restart_o(restart), .scan_o(scan)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    string req = "R1";
    int tab[M];
    int ref_idx = -1;
    bit ref_prev = 1'b0;

    // Reference: index of the active line, -1 when parked in all ones.
    always @(posedge clk) begin
        if (rst) begin
            ref_idx  <= -1;
            ref_prev <= 1'b0;
        end else begin
            ref_prev <= en;
            if (!en)                        ref_idx <= -1;
            else if (!ref_prev || ref_idx < 0) ref_idx <= 0;
            else                            ref_idx <= (ref_idx + 1) % M;
        end
    end

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic step(input bit r, input bit e, input string tag);
        int exp_act;
        @(negedge clk);
        rst = r; en = e; req = tag;
        #2;
        exp_act = (en && ref_idx >= 0) ? (1 << ref_idx) : 0;
        chk(req, int'(act), exp_act);
        chk("R6", int'(restart), (exp_act >> (M-1)) & 1);
        chk("R7", int'(scan), (ref_idx < 0) ? 1 : ((tab[ref_idx] >> (W-1)) & 1));
    endtask

    initial begin
        int c;
        c = 0;
        for (int i = 0; i < M; i++) begin
            tab[i] = c;
            c = ((c << 1) | (((c >> 3) & 1) == ((c >> 2) & 1) ? 1 : 0)) & 15;
        end
        step(1, 0, "R1");
        step(1, 0, "R1");
        step(0, 0, "R1");
        for (int i = 0; i < 4; i++) step(0, 0, "R2");
        step(0, 1, "R9");                // entry cycle, still parked
        step(0, 1, "R3");                // line 0
        for (int i = 0; i < 30; i++) step(0, 1, (i % M == M-2) ? "R5" : "R4");
        step(0, 0, "R2");                // same cycle low: dark
        for (int i = 0; i < 5; i++) step(0, 0, "R8");
        step(0, 1, "R9");
        for (int i = 0; i < 4; i++) step(0, 1, "R4");
        step(0, 0, "R2");
        step(0, 1, "R10");
        for (int i = 0; i < 12; i++) step(0, 1, "R10");
        step(1, 1, "R1");                // reset during the walk
        step(0, 1, "R1");
        for (int i = 0; i < 10; i++) step(0, 1, "R4");
        step(0, 0, "R8");
        step(0, 0, "R8");
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got hang expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule